// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block supports on-chip debug. It holds four breakpoint linear addresses, a control word and a status word. It compares every memory access and every instruction fetch against the enabled breakpoints. Each breakpoint watches an aligned span of 1, 2 or 4 bytes and can be set to fire on instruction fetch, on data write only, or on any data read or write. When a breakpoint hits, the block sets a sticky status flag for that breakpoint and raises a debug exception request. A fetch hit raises the request in the same cycle as the fetch, so the pipeline can stop before the instruction runs. A data hit raises the request in the cycle after the access.

Software reaches the registers through a simple register port. Every request gets a response one cycle later. Requests made at any privilege level other than 0 are refused: the fault output is set, nothing is written and the read data is zero. The status word cannot be loaded directly. Writing it clears every flag whose bit is 1 in the write data. Two event inputs set the single-step flag and the task-switch flag, which sit beside the per-breakpoint flags.

Top module: `bkpt_match_unit`

## Requirements
- R1: After synchronous reset, every address register reads 0x00000000, the control word reads 0x00000400, the status word reads 0x00000FF0, and dbg_req is low.
- R2: Type 00 (execute) matches only fetches (acc_kind 00). On a fetch hit, dbg_req goes high in the same cycle as the access. A data access to the same address does not match.
- R3: Type 01 (write) matches only data writes (acc_kind 10). On a data hit, dbg_req goes high in the cycle after the access. A data read to the same address does not match.
- R4: Type 11 matches data reads (acc_kind 01) and data writes, but not fetches. Type 10 never matches.
- R5: The length field (00 = 1 byte, 01 = 2 bytes, 11 = 4 bytes) sets the span. The low address bits of the breakpoint are cleared to the span's alignment, so an access just past the aligned span does not match.
- R6: A data access covers acc_addr up to acc_addr plus its size minus one (acc_size uses the length encoding). An access matches when that byte range overlaps the span, including misaligned accesses that only partly touch it.
- R7: A breakpoint takes part only while its local bit (control bit 2i) or its global bit (control bit 2i+1) is set. A disabled breakpoint neither sets status nor raises dbg_req.
- R8: Status bit i (bits 3:0) is set by a hit on breakpoint i and stays set until a status write with 1 in bit i clears it. Breakpoints that hit in the same access all set their bits.
- R9: The single-step flag (status bit 14) is set by step_event, and the task-switch flag (status bit 15) is set by task_event. Both are sticky and are cleared by writing 1 to their bit of the status word.
- R10: Register select 0 to 3 picks address register 0 to 3, select 4 picks status and select 5 picks control. Every request gets reg_ack one cycle later, with the read data on reg_rdata. A request with reg_cpl other than 0 returns reg_fault = 1 and data 0, and it changes no register.
- R11: Control bits 15:8 are fixed: bit 10 reads 1 and the others read 0. Status bits 11:4 read 1, and bits 13:12 and 31:16 read 0. Writes do not change these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Linear address of the access |
| acc_kind | input | 2 | 00 fetch, 01 data read, 10 data write |
| acc_size | input | 2 | 00 one byte, 01 two bytes, 11 four bytes |
| step_event | input | 1 | Sets the single-step status flag |
| task_event | input | 1 | Sets the task-switch status flag |
| reg_valid | input | 1 | Register request |
| reg_write | input | 1 | 1 write, 0 read |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_cpl | input | 2 | Privilege level of the requester |
| reg_ack | output | 1 | Response, one cycle after a request |
| reg_fault | output | 1 | Request refused for privilege |
| reg_rdata | output | 32 | Read data |
| dbg_req | output | 1 | Debug exception request |

## Verification
The bench checks the two timing paths separately. A design that registers the fetch path would raise the request one cycle too late, and a design that does not delay the data path would raise it too early. Both show up as a wrong level in a specific cycle. It also covers the span edges. It places a breakpoint at an unaligned address, sends a misaligned 4-byte write that only reaches into the span, and sends an access just past the aligned span. A design without masking, or one that compares start addresses only, would miss or add a hit. Finally, the bench makes refused writes, writes to the fixed bits and partial status clears, then reads the registers back. A design that lets a faulted write land, stores a fixed bit, or clears more than was asked would return the wrong word.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    parameter int NUM_BP = 4;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_STATUS = SEL_W'(4);
    localparam logic [SEL_W-1:0] SEL_CTRL   = SEL_W'(5);

    localparam logic [DATA_W-1:0] CTRL_WMASK = 32'hFFFF_00FF;
    localparam logic [DATA_W-1:0] CTRL_FIXED = 32'h0000_0400;
    localparam logic [DATA_W-1:0] STAT_FIXED = 32'h0000_0FF0;
    localparam int STAT_SS_BIT = 14;
    localparam int STAT_TS_BIT = 15;
    localparam int CFG_BASE    = 16;
    localparam int CFG_STRIDE  = 4;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_NONE  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        BT_EXEC  = 2'b00,
        BT_WRITE = 2'b01,
        BT_RSVD  = 2'b10,
        BT_RW    = 2'b11
    } bp_type_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        acc_kind_e         kind;
        logic [1:0]        size;
    } access_t;

    typedef struct packed {
        bp_type_e   btype;
        logic [1:0] blen;
        logic       en;
    } bp_cfg_t;

    // Offset of the last byte covered, for the shared size/length encoding.
    function automatic logic [1:0] last_offset(input logic [1:0] code);
        return {code[1] & code[0], code[0]};
    endfunction

    function automatic logic kind_allowed(input bp_type_e t, input acc_kind_e k);
        logic ok;
        case (t)
            BT_EXEC:  ok = (k == ACC_FETCH);
            BT_WRITE: ok = (k == ACC_WRITE);
            BT_RW:    ok = (k == ACC_READ) || (k == ACC_WRITE);
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bkpt_comparator.sv
module bkpt_comparator
    import bkpt_pkg::*;
(
    input  logic              acc_valid,
    input  access_t           acc,
    input  logic [ADDR_W-1:0] bp_addr,
    input  bp_cfg_t           cfg,
    output logic              hit
);
    localparam int EXT_W = ADDR_W + 1;

    logic [1:0]        bp_last;
    logic [1:0]        acc_last;
    logic [ADDR_W-1:0] bp_base;
    logic [EXT_W-1:0]  bp_lo, bp_hi, acc_lo, acc_hi;
    logic              overlap;

    always_comb begin
        bp_last  = last_offset(cfg.blen);
        acc_last = last_offset(acc.size);
        bp_base  = bp_addr & ~ADDR_W'(bp_last);
        bp_lo    = {1'b0, bp_base};
        bp_hi    = bp_lo + EXT_W'(bp_last);
        acc_lo   = {1'b0, acc.addr};
        acc_hi   = acc_lo + EXT_W'(acc_last);
        overlap  = (acc_lo <= bp_hi) && (bp_lo <= acc_hi);
        hit      = acc_valid && cfg.en && kind_allowed(cfg.btype, acc.kind) && overlap;
    end

    always_comb begin
        if (hit) begin
            assert_rsvd_type_silent_R4: assert (cfg.btype != BT_RSVD);
        end
    end

endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          reg_valid,
    input  logic                          reg_write,
    input  logic [SEL_W-1:0]              reg_sel,
    input  logic [DATA_W-1:0]             reg_wdata,
    input  logic [1:0]                    reg_cpl,
    input  logic [NUM_BP-1:0]             hit_vec,
    input  logic                          step_event,
    input  logic                          task_event,
    output logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr,
    output bp_cfg_t [NUM_BP-1:0]          bp_cfg,
    output logic                          reg_ack,
    output logic                          reg_fault,
    output logic [DATA_W-1:0]             reg_rdata
);
    logic [NUM_BP-1:0][ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0]             ctrl_q;
    logic [NUM_BP-1:0]             stat_b;
    logic                          ss_q, ts_q;

    logic              priv_ok, wr_ok, rd_ok, stat_clr_en;
    logic [DATA_W-1:0] stat_word, rd_mux;

    assign priv_ok     = (reg_cpl == 2'b00);
    assign wr_ok       = reg_valid && reg_write && priv_ok;
    assign rd_ok       = reg_valid && !reg_write && priv_ok;
    assign stat_clr_en = wr_ok && (reg_sel == SEL_STATUS);
    assign bp_addr     = addr_q;

    for (genvar i = 0; i < NUM_BP; i++) begin : g_cfg
        assign bp_cfg[i].en    = ctrl_q[2*i] | ctrl_q[2*i+1];
        assign bp_cfg[i].btype = bp_type_e'(ctrl_q[CFG_BASE + CFG_STRIDE*i +: 2]);
        assign bp_cfg[i].blen  = ctrl_q[CFG_BASE + CFG_STRIDE*i + 2 +: 2];
    end

    always_comb begin
        stat_word = STAT_FIXED;
        stat_word[NUM_BP-1:0]  = stat_b;
        stat_word[STAT_SS_BIT] = ss_q;
        stat_word[STAT_TS_BIT] = ts_q;
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_BP; i++) begin
            if (reg_sel == SEL_W'(i)) rd_mux = addr_q[i];
        end
        if (reg_sel == SEL_STATUS) rd_mux = stat_word;
        if (reg_sel == SEL_CTRL)   rd_mux = ctrl_q | CTRL_FIXED;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            ctrl_q <= '0;
        end else if (wr_ok) begin
            for (int i = 0; i < NUM_BP; i++) begin
                if (reg_sel == SEL_W'(i)) addr_q[i] <= reg_wdata;
            end
            if (reg_sel == SEL_CTRL) ctrl_q <= reg_wdata & CTRL_WMASK;
        end
    end

    // Sticky flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_b <= '0;
            ss_q   <= 1'b0;
            ts_q   <= 1'b0;
        end else begin
            stat_b <= (stat_b & ~(stat_clr_en ? reg_wdata[NUM_BP-1:0] : '0)) | hit_vec;
            ss_q   <= (ss_q & ~(stat_clr_en & reg_wdata[STAT_SS_BIT])) | step_event;
            ts_q   <= (ts_q & ~(stat_clr_en & reg_wdata[STAT_TS_BIT])) | task_event;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_ack   <= 1'b0;
            reg_fault <= 1'b0;
            reg_rdata <= '0;
        end else begin
            reg_ack   <= reg_valid;
            reg_fault <= reg_valid && !priv_ok;
            reg_rdata <= rd_ok ? rd_mux : '0;
        end
    end

    assert_fault_keeps_ctrl_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && reg_write && reg_cpl != 2'b00) |=> $stable(ctrl_q) && $stable(addr_q));

    assert_ack_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
        reg_valid |=> reg_ack);

    for (genvar i = 0; i < NUM_BP; i++) begin : g_chk
        assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (rst)
            (stat_b[i] && !(stat_clr_en && reg_wdata[i])) |=> stat_b[i]);
        assert_set_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
            $rose(stat_b[i]) |-> $past(bp_cfg[i].en));
    end

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        acc_size,
    input  logic              step_event,
    input  logic              task_event,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [1:0]        reg_cpl,
    output logic              reg_ack,
    output logic              reg_fault,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              dbg_req
);
    access_t                       acc;
    logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr;
    bp_cfg_t [NUM_BP-1:0]          bp_cfg;
    logic [NUM_BP-1:0]             hit_vec;
    logic                          fetch_hit, data_hit, data_hit_q;

    assign acc.addr = acc_addr;
    assign acc.kind = acc_kind_e'(acc_kind);
    assign acc.size = acc_size;

    for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
        bkpt_comparator u_cmp (
            .acc_valid (acc_valid),
            .acc       (acc),
            .bp_addr   (bp_addr[i]),
            .cfg       (bp_cfg[i]),
            .hit       (hit_vec[i])
        );
    end

    bkpt_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_valid  (reg_valid),
        .reg_write  (reg_write),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_cpl    (reg_cpl),
        .hit_vec    (hit_vec),
        .step_event (step_event),
        .task_event (task_event),
        .bp_addr    (bp_addr),
        .bp_cfg     (bp_cfg),
        .reg_ack    (reg_ack),
        .reg_fault  (reg_fault),
        .reg_rdata  (reg_rdata)
    );

    assign fetch_hit = (|hit_vec) && (acc.kind == ACC_FETCH);
    assign data_hit  = (|hit_vec) && (acc.kind != ACC_FETCH);

    always_ff @(posedge clk) begin
        if (rst) data_hit_q <= 1'b0;
        else     data_hit_q <= data_hit;
    end

    // Fetch hits stop the instruction in the same cycle; data hits trap after the access.
    assign dbg_req = fetch_hit | data_hit_q;

    assert_data_trap_next_R3: assert property (@(posedge clk) disable iff (rst)
        data_hit |=> dbg_req);

    assert_fetch_no_delay_R2: assert property (@(posedge clk) disable iff (rst)
        (dbg_req && !$past(data_hit)) |-> (acc_valid && acc_kind == 2'b00));

endmodule

// File: tb/bkpt_match_unit_bench.sv
module bkpt_match_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic [1:0]  acc_size = '0;
    logic        step_event = 1'b0;
    logic        task_event = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_cpl = '0;
    logic        reg_ack, reg_fault, dbg_req;
    logic [31:0] reg_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        fault;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #5 clk = ~clk;

    bkpt_match_unit u_bkpt_match_unit (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_size(acc_size),
        .step_event(step_event), .task_event(task_event),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_cpl(reg_cpl),
        .reg_ack(reg_ack), .reg_fault(reg_fault), .reg_rdata(reg_rdata),
        .dbg_req(dbg_req)
    );

    // Monitor: pops expected register responses as the design acknowledges.
    always @(posedge clk) begin
        #2;
        if (!rst && reg_ack) begin
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL unexpected response: got %h/%0d expected none", reg_rdata, reg_fault);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                vectors++;
                if (reg_rdata !== it.data || reg_fault !== it.fault) begin
                    miscompares++;
                    $display("FAIL %s: got data %h fault %0d expected data %h fault %0d",
                             it.tag, reg_rdata, reg_fault, it.data, it.fault);
                end
            end
        end
    end

    task automatic reg_op(input logic wr, input logic [2:0] sel, input logic [31:0] wd,
                          input logic [1:0] cpl, input logic [31:0] exp_d,
                          input logic exp_f, input string tag);
        exp_item_t it;
        @(negedge clk);
        reg_valid = 1'b1; reg_write = wr; reg_sel = sel; reg_wdata = wd; reg_cpl = cpl;
        it.data = exp_d; it.fault = exp_f; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; reg_wdata = '0; reg_cpl = '0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] wd, input string tag);
        reg_op(1'b1, sel, wd, 2'b00, 32'h0, 1'b0, tag);
    endtask

    task automatic rd(input logic [2:0] sel, input logic [31:0] exp_d, input string tag);
        reg_op(1'b0, sel, 32'h0, 2'b00, exp_d, 1'b0, tag);
    endtask

    task automatic check_req(input logic exp, input string tag);
        vectors++;
        if (dbg_req !== exp) begin
            miscompares++;
            $display("FAIL %s: dbg_req got %0d expected %0d", tag, dbg_req, exp);
        end
    endtask

    // kind: 0 fetch, 1 read, 2 write; size: 0 one, 1 two, 3 four bytes
    task automatic access(input logic [31:0] a, input logic [1:0] k, input logic [1:0] s,
                          input logic exp_now, input logic exp_next, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_size = s;
        #2 check_req(exp_now, {tag, " same cycle"});
        @(negedge clk);
        acc_valid = 1'b0;
        #2 check_req(exp_next, {tag, " next cycle"});
    endtask

    initial begin
        #100000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2 check_req(1'b0, "R1 reset dbg_req");
        rd(3'd5, 32'h0000_0400, "R1 control after reset");
        rd(3'd4, 32'h0000_0FF0, "R1 status after reset");
        rd(3'd0, 32'h0000_0000, "R1 address0 after reset");

        // Breakpoint 0: execute, 1 byte, local enable
        wr(3'd0, 32'h0000_1000, "R10 write addr0");
        wr(3'd5, 32'h0000_0001, "R10 write ctrl");
        rd(3'd5, 32'h0000_0401, "R11 ctrl readback");
        access(32'h1000, 2'd0, 2'd0, 1'b1, 1'b0, "R2 fetch hit");
        access(32'h1000, 2'd1, 2'd0, 1'b0, 1'b0, "R2 read on exec bp");
        access(32'h1001, 2'd0, 2'd0, 1'b0, 1'b0, "R2 fetch miss");
        rd(3'd4, 32'h0000_0FF1, "R8 status after fetch hit");
        wr(3'd4, 32'h0000_0001, "R8 clear bit0");
        rd(3'd4, 32'h0000_0FF0, "R8 status cleared");

        // Breakpoint 1: write, 4 bytes, global enable, unaligned address
        wr(3'd1, 32'h0000_2003, "R5 write addr1");
        wr(3'd5, 32'h00D0_0009, "R3 write ctrl");
        access(32'h2002, 2'd2, 2'd0, 1'b0, 1'b1, "R3 write hit");
        access(32'h2002, 2'd1, 2'd0, 1'b0, 1'b0, "R3 read on write bp");
        access(32'h2000, 2'd0, 2'd0, 1'b0, 1'b0, "R3 fetch on write bp");
        access(32'h1FFE, 2'd2, 2'd3, 1'b0, 1'b1, "R6 misaligned overlap");
        access(32'h1FFC, 2'd2, 2'd1, 1'b0, 1'b0, "R6 below span");
        access(32'h2004, 2'd2, 2'd3, 1'b0, 1'b0, "R5 above span");
        rd(3'd4, 32'h0000_0FF2, "R8 status bit1");
        wr(3'd4, 32'h0000_000F, "R8 clear all");

        // Breakpoint 2: read/write, 2 bytes
        wr(3'd2, 32'h0000_3001, "R5 write addr2");
        wr(3'd5, 32'h07D0_0019, "R4 write ctrl");
        access(32'h3001, 2'd1, 2'd0, 1'b0, 1'b1, "R4 read hit");
        access(32'h3000, 2'd2, 2'd0, 1'b0, 1'b1, "R5 masked base write hit");
        access(32'h3002, 2'd1, 2'd0, 1'b0, 1'b0, "R5 past 2-byte span");
        access(32'h3000, 2'd0, 2'd0, 1'b0, 1'b0, "R4 fetch on rw bp");

        // Breakpoint 3: reserved type 10
        wr(3'd3, 32'h0000_4000, "R4 write addr3");
        wr(3'd5, 32'h27D0_0099, "R4 ctrl reserved type");
        access(32'h4000, 2'd2, 2'd0, 1'b0, 1'b0, "R4 reserved write");
        access(32'h4000, 2'd1, 2'd0, 1'b0, 1'b0, "R4 reserved read");
        access(32'h4000, 2'd0, 2'd0, 1'b0, 1'b0, "R4 reserved fetch");
        rd(3'd4, 32'h0000_0FF4, "R8 status only bit2");
        wr(3'd4, 32'h0000_000F, "R8 clear all");

        // All disabled
        wr(3'd5, 32'h27D0_0000, "R7 disable all");
        access(32'h1000, 2'd0, 2'd0, 1'b0, 1'b0, "R7 disabled fetch");
        access(32'h2002, 2'd2, 2'd0, 1'b0, 1'b0, "R7 disabled write");
        rd(3'd4, 32'h0000_0FF0, "R7 status untouched");

        // Two breakpoints in one access
        wr(3'd2, 32'h0000_2000, "R8 move addr2");
        wr(3'd5, 32'h27D0_0055, "R8 enable all local");
        access(32'h2001, 2'd2, 2'd0, 1'b0, 1'b1, "R8 double hit");
        rd(3'd4, 32'h0000_0FF6, "R8 status bits 1 and 2");

        // Privilege
        reg_op(1'b0, 3'd5, 32'h0, 2'd3, 32'h0, 1'b1, "R10 read at level 3");
        reg_op(1'b1, 3'd0, 32'hDEAD_BEEF, 2'd1, 32'h0, 1'b1, "R10 write at level 1");
        rd(3'd0, 32'h0000_1000, "R10 addr0 unchanged");
        reg_op(1'b1, 3'd4, 32'hFFFF_FFFF, 2'd2, 32'h0, 1'b1, "R10 clear at level 2");
        rd(3'd4, 32'h0000_0FF6, "R10 status unchanged");

        // Fixed bits
        wr(3'd5, 32'hFFFF_FFFF, "R11 ctrl all ones");
        rd(3'd5, 32'hFFFF_04FF, "R11 ctrl fixed bits");
        wr(3'd5, 32'h0000_0000, "R11 ctrl zero");
        rd(3'd5, 32'h0000_0400, "R11 ctrl fixed one");
        wr(3'd4, 32'hFFFF_FFFF, "R11 status all ones");
        rd(3'd4, 32'h0000_0FF0, "R11 status fixed bits");

        // Single-step and task-switch flags
        @(negedge clk); step_event = 1'b1;
        @(negedge clk); step_event = 1'b0;
        rd(3'd4, 32'h0000_4FF0, "R9 single-step flag");
        @(negedge clk); task_event = 1'b1;
        @(negedge clk); task_event = 1'b0;
        rd(3'd4, 32'h0000_CFF0, "R9 task-switch flag");
        wr(3'd4, 32'h0000_4000, "R9 clear single-step");
        rd(3'd4, 32'h0000_8FF0, "R9 only task-switch left");
        wr(3'd4, 32'h0000_8000, "R9 clear task-switch");
        rd(3'd4, 32'h0000_0FF0, "R9 flags clear");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            miscompares++;
            $display("FAIL R10 missing responses: got %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule